// File: doc/BRIEF.md
# Multi-Channel Interval Timer Bank

This peripheral holds a configurable number of identical 32-bit timer channels behind one word-addressed register port. Each channel owns four consecutive words: a control/status word, a load value, the live count and a spare word. Software writes a load value, then starts the channel by writing the control word with its run bit set. The channel then steps once per clock, either downward to zero or upward to all-ones. At that terminal value it raises a sticky expiry flag, and it either reloads and keeps going or halts.

The expiry flags of all channels are gated by each channel's own interrupt enable and merged onto a single interrupt line. Reads are combinational from the address. Writes take effect at the next rising clock edge. Only whole 32-bit words are transferred.

Top module: `timer_bank`

## Requirements
- R1: After reset every word of every channel reads zero and `irq` is low.
- R2: Word address bits [ADDR_W-1:2] select the channel and bits [1:0] select the word: 0 control, 1 load, 2 count, 3 spare. The load and spare words read back what was last written.
- R3: A control write with bit 7 (run) set makes the count equal the load value at that edge. A write to the count word never changes the count.
- R4: With control bit 1 set (down), a running count falls by one per clock. A clock that starts with the count at zero sets the flag (control bit 8) instead of stepping. With a load of zero, this happens on the first clock after the start.
- R5: With control bit 1 clear (up), a running count rises by one per clock. A clock that starts with the count at 0xFFFFFFFF sets the flag.
- R6: On expiry with control bit 4 (reload) set, the count takes the load value and the channel keeps running. With bit 4 clear, the channel halts holding the terminal value.
- R7: A control write with bit 7 clear stops the channel, and the count holds its value from then on.
- R8: A control write with bit 8 set clears the flag. A control write with bit 8 clear leaves the flag as it was. A bus write never sets the flag.
- R9: `irq` is high exactly when some channel has both its flag (bit 8) and its interrupt enable (bit 6) set, starting from the edge that changed either one.
- R10: A channel index at or above NUM_CHAN reads zero, and writes to it change no channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the addressed word |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Shared interrupt request |

## Verification
The bench builds the block with three channels and a five-bit word address. That leaves five channel slots, indices 3 to 7, that are decoded but unpopulated, so the out-of-range read and write rules can be reached. Three channels are enough to run a down counter, an up counter with reload and a frozen counter side by side. The short loads used bring both terminal values within a few cycles. This includes a load of zero and loads just below all-ones.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W    = 32;
  localparam int CTL_DOWN  = 1;
  localparam int CTL_RELD  = 4;
  localparam int CTL_IEN   = 6;
  localparam int CTL_RUN   = 7;
  localparam int CTL_FLAG  = 8;

  localparam logic [1:0] WORD_CTL   = 2'd0;
  localparam logic [1:0] WORD_LOAD  = 2'd1;
  localparam logic [1:0] WORD_COUNT = 2'd2;
  localparam logic [1:0] WORD_SPARE = 2'd3;

  typedef struct packed {
    logic ctlWr;
    logic loadWr;
    logic spareWr;
  } chanStrb_t;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
#(
  parameter int NUM_CHAN = 4,
  parameter int ADDR_W   = 6,
  localparam int IDX_W   = ADDR_W - 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      addr,
  output chanStrb_t [NUM_CHAN-1:0] strb,
  output logic                   rdHit,
  output logic [IDX_W-1:0]       rdIdx,
  output logic [1:0]             rdWord
);
  logic [IDX_W-1:0] chanIdx;
  logic [1:0]       wordSel;
  logic             inRange;
  logic [NUM_CHAN-1:0] anyWr;

  assign chanIdx = addr[ADDR_W-1:2];
  assign wordSel = addr[1:0];
  assign inRange = 32'(chanIdx) < NUM_CHAN;

  assign rdHit  = inRange;
  assign rdIdx  = chanIdx;
  assign rdWord = wordSel;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_strb
    logic sel;
    assign sel = wrEn && inRange && (chanIdx == IDX_W'(c));
    assign strb[c].ctlWr   = sel && (wordSel == WORD_CTL);
    assign strb[c].loadWr  = sel && (wordSel == WORD_LOAD);
    assign strb[c].spareWr = sel && (wordSel == WORD_SPARE);
    assign anyWr[c] = strb[c].ctlWr | strb[c].loadWr | strb[c].spareWr;
  end

  AST_OOR_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (32'(addr[ADDR_W-1:2]) >= NUM_CHAN)) |-> (anyWr == '0)); // R10

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(anyWr)); // R2
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  chanStrb_t         strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctlOut,
  output logic [DATA_W-1:0] loadOut,
  output logic [DATA_W-1:0] cntOut,
  output logic [DATA_W-1:0] spareOut,
  output logic              irqReq
);
  logic [DATA_W-1:0] ctlReg, loadQ, cntQ, spareQ;
  logic flagQ, runQ;
  logic stepping, atTerm, expire, isDown;

  assign isDown   = ctlReg[CTL_DOWN];
  assign atTerm   = isDown ? (cntQ == '0) : (cntQ == '1);
  assign stepping = runQ && ctlReg[CTL_RUN] && !strb.ctlWr;
  assign expire   = stepping && atTerm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg <= '0;
      loadQ  <= '0;
      spareQ <= '0;
      cntQ   <= '0;
      flagQ  <= 1'b0;
      runQ   <= 1'b0;
    end else begin
      if (strb.loadWr)  loadQ  <= wdata;
      if (strb.spareWr) spareQ <= wdata;
      if (strb.ctlWr) begin
        ctlReg <= wdata & ~(DATA_W'(1) << CTL_FLAG);
        runQ   <= wdata[CTL_RUN];
        if (wdata[CTL_FLAG]) flagQ <= 1'b0;
        if (wdata[CTL_RUN])  cntQ  <= loadQ;
      end else if (stepping) begin
        if (atTerm) begin
          flagQ <= 1'b1;
          if (ctlReg[CTL_RELD]) cntQ <= loadQ;
          else                  runQ <= 1'b0;
        end else if (isDown) begin
          cntQ <= cntQ - 1'b1;
        end else begin
          cntQ <= cntQ + 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctlOut = ctlReg;
    ctlOut[CTL_FLAG] = flagQ;
  end
  assign loadOut  = loadQ;
  assign cntOut   = cntQ;
  assign spareOut = spareQ;
  assign irqReq   = flagQ && ctlReg[CTL_IEN];

  AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ctlWr && wdata[CTL_RUN]) |=> (cntQ == $past(loadQ))); // R3

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (stepping && !atTerm) |=>
      (cntQ == ($past(isDown) ? $past(cntQ) - 1'b1 : $past(cntQ) + 1'b1))); // R4

  AST_FLAG_AT_TERM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> ($past(isDown) ? ($past(cntQ) == '0) : ($past(cntQ) == '1))); // R4

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (stepping && !isDown && cntQ == '1) |=> flagQ); // R5

  AST_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (expire && ctlReg[CTL_RELD]) |=> (cntQ == $past(loadQ) && runQ)); // R6

  AST_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlReg[CTL_RUN] && !strb.ctlWr) |=> $stable(cntQ)); // R7

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ctlWr && wdata[CTL_FLAG]) |=> !flagQ); // R8
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import tmr_pkg::*;
#(
  parameter int NUM_CHAN = 4,
  parameter int ADDR_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;

  chanStrb_t [NUM_CHAN-1:0] strb;
  logic                     rdHit;
  logic [IDX_W-1:0]         rdIdx;
  logic [1:0]               rdWord;
  logic [DATA_W-1:0] ctlV [NUM_CHAN];
  logic [DATA_W-1:0] loadV[NUM_CHAN];
  logic [DATA_W-1:0] cntV [NUM_CHAN];
  logic [DATA_W-1:0] sparV[NUM_CHAN];
  logic [NUM_CHAN-1:0] irqReq, flagVec;

  tmr_decode #(.NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .strb(strb), .rdHit(rdHit), .rdIdx(rdIdx), .rdWord(rdWord));

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    tmr_chan u_chan (
      .clk(clk), .rstN(rstN), .strb(strb[c]), .wdata(wdata),
      .ctlOut(ctlV[c]), .loadOut(loadV[c]), .cntOut(cntV[c]),
      .spareOut(sparV[c]), .irqReq(irqReq[c]));
    assign flagVec[c] = ctlV[c][CTL_FLAG];
  end

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NUM_CHAN; c++) begin
      if (rdHit && (32'(rdIdx) == c)) begin
        case (rdWord)
          WORD_CTL:   rdata = ctlV[c];
          WORD_LOAD:  rdata = loadV[c];
          WORD_COUNT: rdata = cntV[c];
          default:    rdata = sparV[c];
        endcase
      end
    end
  end

  assign irq = |irqReq;

  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flagVec != '0)); // R9
endmodule

// File: tb/tb_timer_bank.sv
`timescale 1ns/1ps
module tb_timer_bank;
  localparam int NC = 3;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;

  int vecs = 0;
  int errs = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  timer_bank #(.NUM_CHAN(NC), .ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  // behavioural reference
  logic [31:0] mCtl[NC], mLoad[NC], mCnt[NC], mSpare[NC];
  bit mFlag[NC], mRun[NC];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NC; c++) begin
        mCtl[c] <= 0; mLoad[c] <= 0; mCnt[c] <= 0; mSpare[c] <= 0;
        mFlag[c] <= 0; mRun[c] <= 0;
      end
    end else begin
      for (int c = 0; c < NC; c++) begin
        bit mine;
        mine = wrEn && (int'(addr[AW-1:2]) == c);
        if (mine && addr[1:0] == 2'd0) begin
          mCtl[c] <= wdata & 32'hFFFF_FEFF;
          mRun[c] <= wdata[7];
          if (wdata[8]) mFlag[c] <= 0;
          if (wdata[7]) mCnt[c] <= mLoad[c];
        end else begin
          if (mine && addr[1:0] == 2'd1) mLoad[c] <= wdata;
          if (mine && addr[1:0] == 2'd3) mSpare[c] <= wdata;
          if (mRun[c]) begin
            if ((mCtl[c][1] && mCnt[c] == 0) || (!mCtl[c][1] && mCnt[c] == 32'hFFFF_FFFF)) begin
              mFlag[c] <= 1;
              if (mCtl[c][4]) mCnt[c] <= mLoad[c];
              else mRun[c] <= 0;
            end else if (mCtl[c][1]) mCnt[c] <= mCnt[c] - 1;
            else mCnt[c] <= mCnt[c] + 1;
          end
        end
      end
    end
  end

  function automatic logic [31:0] expRd(logic [AW-1:0] a);
    int c;
    c = int'(a[AW-1:2]);
    if (c >= NC) return 0;
    case (a[1:0])
      2'd0: return mCtl[c] | (mFlag[c] ? 32'h100 : 32'h0);
      2'd1: return mLoad[c];
      2'd2: return mCnt[c];
      default: return mSpare[c];
    endcase
  endfunction

  function automatic logic expIrq();
    logic r;
    r = 0;
    for (int c = 0; c < NC; c++) r |= mFlag[c] && mCtl[c][6];
    return r;
  endfunction

  function automatic string tagOf(logic [AW-1:0] a);
    if (int'(a[AW-1:2]) >= NC) return "R10";
    case (a[1:0])
      2'd0: return "R8";
      2'd2: return "R4";
      default: return "R2";
    endcase
  endfunction

  // per-cycle comparison against the reference
  always @(posedge clk) begin
    if (running) begin
      #1;
      vecs++;
      if (rdata !== expRd(addr)) begin
        errs++;
        $display("FAIL %s addr=%0d rdata actual=%h expected=%h", tagOf(addr), addr, rdata, expRd(addr));
      end
      vecs++;
      if (irq !== expIrq()) begin
        errs++;
        $display("FAIL R9 irq actual=%b expected=%b", irq, expIrq());
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdAt(logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk); addr = a;
    @(posedge clk); #1; v = rdata;
  endtask

  function automatic logic [AW-1:0] A(int ch, int w);
    return AW'(ch * 4 + w);
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    errs++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    running = 1'b1;
    // R1: everything zero after reset
    for (int a = 0; a < NC * 4; a++) begin
      rdAt(AW'(a), v);
      chk("R1", v, 32'h0);
    end
    chk("R1", {31'b0, irq}, 32'h0);

    // R2: load and spare read back
    wr(A(0, 1), 32'd5);
    wr(A(0, 3), 32'hA5A5_0003);
    wr(A(1, 3), 32'h5A5A_1111);
    rdAt(A(0, 1), v); chk("R2", v, 32'd5);
    rdAt(A(0, 3), v); chk("R2", v, 32'hA5A5_0003);
    rdAt(A(1, 3), v); chk("R2", v, 32'h5A5A_1111);

    // R4: down count from 5 with interrupt enable
    wr(A(0, 0), 32'h0000_00C2);
    rdAt(A(0, 2), v); chk("R4", v, 32'd3);
    repeat (10) @(negedge clk);
    rdAt(A(0, 0), v); chk("R4", v, 32'h0000_01C2);
    rdAt(A(0, 2), v); chk("R6", v, 32'd0);
    chk("R9", {31'b0, irq}, 32'd1);

    // R3: count word writes have no effect
    wr(A(0, 2), 32'h0000_1234);
    rdAt(A(0, 2), v); chk("R3", v, 32'd0);

    // R8: clear with bit 8
    wr(A(0, 0), 32'h0000_0142);
    rdAt(A(0, 0), v); chk("R8", v, 32'h0000_0042);
    chk("R9", {31'b0, irq}, 32'd0);

    // R5/R6: up count with reload, no interrupt enable
    wr(A(1, 1), 32'hFFFF_FFFC);
    wr(A(1, 0), 32'h0000_0090);
    rdAt(A(1, 2), v); chk("R5", v, 32'hFFFF_FFFE);
    repeat (12) @(negedge clk);
    rdAt(A(1, 0), v); chk("R5", v, 32'h0000_0190);
    chk("R9", {31'b0, irq}, 32'd0);

    // R4 corner: load zero expires one clock after start
    wr(A(0, 1), 32'd0);
    wr(A(0, 0), 32'h0000_00C2);
    rdAt(A(0, 0), v); chk("R4", v, 32'h0000_01C2);
    chk("R9", {31'b0, irq}, 32'd1);
    wr(A(0, 0), 32'h0000_0042);
    rdAt(A(0, 0), v); chk("R8", v, 32'h0000_0142);
    wr(A(0, 0), 32'h0000_0002);
    rdAt(A(0, 0), v); chk("R8", v, 32'h0000_0102);
    chk("R9", {31'b0, irq}, 32'd0);
    wr(A(0, 0), 32'h0000_0100);
    rdAt(A(0, 0), v); chk("R8", v, 32'h0);

    // R7: freeze a running down counter
    wr(A(2, 1), 32'd100);
    wr(A(2, 0), 32'h0000_0082);
    repeat (5) @(negedge clk);
    wr(A(2, 0), 32'h0000_0002);
    repeat (4) @(negedge clk);
    rdAt(A(2, 2), v); chk("R7", v, 32'd94);
    repeat (6) @(negedge clk);
    rdAt(A(2, 2), v); chk("R7", v, 32'd94);

    // R10: unpopulated channels
    wr(A(5, 1), 32'h0000_DEAD);
    rdAt(A(5, 1), v); chk("R10", v, 32'h0);
    rdAt(A(7, 3), v); chk("R10", v, 32'h0);
    rdAt(A(1, 1), v); chk("R10", v, 32'hFFFF_FFFC);

    // R6: up count without reload halts at all-ones
    wr(A(2, 1), 32'hFFFF_FFFE);
    wr(A(2, 0), 32'h0000_0080);
    repeat (5) @(negedge clk);
    rdAt(A(2, 2), v); chk("R6", v, 32'hFFFF_FFFF);
    rdAt(A(2, 0), v); chk("R5", v, 32'h0000_0180);

    repeat (4) @(negedge clk);
    running = 1'b0;
    finishRun();
  end
endmodule